// File: doc/BRIEF.md
# Queued Configuration-Set Loader

This block sits in front of a frame-processing engine and lets software line up the engine's next job. Software writes one pointer: the byte address of a block of memory that holds a complete set of engine configuration words. The block keeps that pointer until the engine is free. It then reads the words one after another over a simple read-request/read-response port and puts them in a shadow store. When the last word has arrived, it copies the whole set into the live configuration registers in one clock edge and starts the engine.

If the engine is idle when the pointer is written, the fetch begins at once. If a frame is still being processed, the fetch waits for the engine's done pulse. Because of this, software programs the first frame and every later frame in the same way.

The live set includes a control word (word 0) whose bit `IRQ_EN_BIT` enables the frame-done interrupt. The interrupt for a frame is always taken from the control word that was live while that frame ran.

Top module: `cfgq_loader`

## Requirements
- R1: After reset, `busy`, `pending`, `eng_start`, `irq` and `rd_req_valid` are 0, and every bit of `cfg_flat` is 0.
- R2: A pointer written while the loader is idle is reported on `pending` in the next cycle. One cycle after that, `pending` is back at 0 and `busy` is 1, because the fetch has begun.
- R3: A job issues exactly `NWORDS` read requests, at byte addresses base, base+4, base+8 and so on in ascending order. A new request is issued only after the previous response has been received.
- R4: The read-request port follows valid/ready rules. Once `rd_req_valid` is raised, it and `rd_req_addr` hold steady until the cycle in which `rd_req_ready` is 1.
- R5: `cfg_flat` does not change while words are being fetched. All `NWORDS` words are updated together in one cycle, after the last response. The word read from base+4k appears at `cfg_flat[32k +: 32]`.
- R6: `eng_start` is a one-cycle pulse, raised in the cycle right after the commit, when `cfg_flat` already holds the new set. `busy` stays 1 from the start of the fetch until the cycle after `eng_done`, when no job is pending.
- R7: A pointer written while `busy` is 1 starts no read request until the engine's `eng_done` pulse. The fetch then uses that pointer.
- R8: A second pointer write while a job is pending replaces the stored pointer. Only one job is run, using the latest pointer.
- R9: `irq` is a one-cycle pulse in the cycle after `eng_done`. It is raised exactly when bit `IRQ_EN_BIT` (default 1) of `cfg_flat` word 0 was 1 during the frame that just finished.
- R10: Bits [1:0] of the written pointer are ignored. The fetch base is the pointer with those two bits cleared.
- R11: `rd_rsp_ready` is 1 only while a read request is outstanding. A response is taken only in a cycle where both `rd_rsp_valid` and `rd_rsp_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Pointer register write strobe |
| ptr_wr_addr | input | AW | Byte address of the next configuration set |
| pending | output | 1 | A pointer is stored and its fetch has not yet begun |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | AW | Word-aligned byte address of the read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader accepts a response (only while a read is outstanding) |
| rd_rsp_data | input | DW | Read response word |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_done | input | 1 | One-cycle engine frame-done pulse |
| busy | output | 1 | A fetch, commit or frame is in progress |
| irq | output | 1 | Frame-done interrupt pulse |
| cfg_flat | output | NWORDS*DW | Live configuration words, word k at bits [DW*k +: DW] |

## Verification
The assertions check the following on every cycle:
- at most one read is outstanding;
- a stalled request keeps its address;
- request addresses are aligned;
- `cfg_flat` changes only on the commit edge;
- the start pulse lasts one cycle;
- no read is issued while a frame runs;
- every interrupt follows a done pulse.

Some behaviour can only be shown by the bench's scenarios:
- whether the right words land in the right slots;
- whether a pointer written while busy waits for the frame to end;
- whether a second write while pending replaces the first;
- whether the interrupt uses the old enable bit rather than the newly fetched one.

The bench sweeps request stalls and response delays over many pointers to exercise these behaviours.

// File: rtl/cfgq_pkg.sv
package cfgq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_COMMIT = 2'd2,
    ST_RUN    = 2'd3
  } ldr_state_e;

endpackage

// File: rtl/cfgq_ptr_slot.sv
module cfgq_ptr_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          take,
  output logic          pending,
  output logic [AW-1:0] ptr
);

  logic addr_lsb_unused;
  assign addr_lsb_unused = ^wr_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ptr     <= '0;
    end else begin
      if (wr_en) begin
        ptr     <= {wr_addr[AW-1:2], 2'b00};
        pending <= 1'b1;
      end else if (take) begin
        pending <= 1'b0;
      end
    end
  end

  // R8: a write always leaves a job pending
  p_pending_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending);

  // R10: stored pointer is word aligned
  p_ptr_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ptr[1:0] == 2'b00);

endmodule

// File: rtl/cfgq_word_fetch.sv
module cfgq_word_fetch #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NWORDS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [AW-1:0]        base,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [AW-1:0]        req_addr,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [DW-1:0]        rsp_data,
  output logic                 last,
  output logic [NWORDS*DW-1:0] shadow_flat
);

  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic          active;
  logic          outstanding;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic          req_fire;
  logic          rsp_fire;

  assign req_valid = active && !outstanding;
  assign req_addr  = base_q + AW'({idx, 2'b00});
  assign rsp_ready = outstanding;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && outstanding;
  assign last      = rsp_fire && (idx == IW'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      outstanding <= 1'b0;
      idx         <= '0;
      base_q      <= '0;
    end else begin
      if (go) begin
        active      <= 1'b1;
        outstanding <= 1'b0;
        idx         <= '0;
        base_q      <= base;
      end else begin
        if (req_fire) outstanding <= 1'b1;
        if (rsp_fire) begin
          outstanding <= 1'b0;
          if (last) begin
            active <= 1'b0;
            idx    <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_flat <= '0;
    end else if (rsp_fire) begin
      shadow_flat[idx*DW +: DW] <= rsp_data;
    end
  end

  // R3: a single read in flight
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);

  // R4: a stalled request keeps its valid and address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R10: request addresses are word aligned
  p_req_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  // R11: a fresh fetch never starts with a response accepted
  p_rsp_only_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !rsp_ready);

endmodule

// File: rtl/cfgq_live_bank.sv
module cfgq_live_bank #(
  parameter int DW         = 32,
  parameter int NWORDS     = 40,
  parameter int IRQ_EN_BIT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [NWORDS*DW-1:0] shadow_flat,
  output logic [NWORDS*DW-1:0] cfg_flat,
  output logic                 irq_en
);

  logic [DW-1:0] live [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)      live[k] <= '0;
      else if (commit) live[k] <= shadow_flat[k*DW +: DW];
    end
    assign cfg_flat[k*DW +: DW] = live[k];
  end

  assign irq_en = live[0][IRQ_EN_BIT];

  // R5: live set changes only on the commit edge
  p_atomic_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_flat));

endmodule

// File: rtl/cfgq_loader.sv
module cfgq_loader
  import cfgq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NWORDS     = 40,
  parameter int IRQ_EN_BIT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_wr_en,
  input  logic [AW-1:0]        ptr_wr_addr,
  output logic                 pending,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [AW-1:0]        rd_req_addr,
  input  logic                 rd_rsp_valid,
  output logic                 rd_rsp_ready,
  input  logic [DW-1:0]        rd_rsp_data,
  output logic                 eng_start,
  input  logic                 eng_done,
  output logic                 busy,
  output logic                 irq,
  output logic [NWORDS*DW-1:0] cfg_flat
);

  ldr_state_e            state, state_nxt;
  logic                  take;
  logic                  commit;
  logic                  fetch_last;
  logic [AW-1:0]         ptr;
  logic [NWORDS*DW-1:0]  shadow_flat;
  logic                  irq_en;
  logic                  start_q;
  logic                  irq_q;

  cfgq_ptr_slot #(.AW(AW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ptr_wr_en),
    .wr_addr (ptr_wr_addr),
    .take    (take),
    .pending (pending),
    .ptr     (ptr)
  );

  cfgq_word_fetch #(.AW(AW), .DW(DW), .NWORDS(NWORDS)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (take),
    .base        (ptr),
    .req_valid   (rd_req_valid),
    .req_ready   (rd_req_ready),
    .req_addr    (rd_req_addr),
    .rsp_valid   (rd_rsp_valid),
    .rsp_ready   (rd_rsp_ready),
    .rsp_data    (rd_rsp_data),
    .last        (fetch_last),
    .shadow_flat (shadow_flat)
  );

  cfgq_live_bank #(.DW(DW), .NWORDS(NWORDS), .IRQ_EN_BIT(IRQ_EN_BIT)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .shadow_flat (shadow_flat),
    .cfg_flat    (cfg_flat),
    .irq_en      (irq_en)
  );

  always_comb begin
    state_nxt = state;
    take      = 1'b0;
    commit    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pending) begin
          take      = 1'b1;
          state_nxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetch_last) state_nxt = ST_COMMIT;
      end
      ST_COMMIT: begin
        commit    = 1'b1;
        state_nxt = ST_RUN;
      end
      ST_RUN: begin
        if (eng_done) begin
          if (pending) begin
            take      = 1'b1;
            state_nxt = ST_FETCH;
          end else begin
            state_nxt = ST_IDLE;
          end
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state   <= state_nxt;
      start_q <= commit;
      irq_q   <= (state == ST_RUN) && eng_done && irq_en;
    end
  end

  assign eng_start = start_q;
  assign irq       = irq_q;
  assign busy      = (state != ST_IDLE);

  // R6: start is a single-cycle pulse
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R6: start only right after a commit
  p_start_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(state == ST_COMMIT));

  // R7: no reads while a frame is running
  p_no_fetch_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> !rd_req_valid);

  // R9: interrupt only after a done pulse
  p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(eng_done));

endmodule

// File: tb/cfgq_loader_tb_top.sv
`timescale 1ns/1ps
module cfgq_loader_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int N  = 4;
  localparam int IE = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ptr_wr_en = 1'b0;
  logic [AW-1:0]   ptr_wr_addr = '0;
  logic            pending;
  logic            rd_req_valid;
  logic            rd_req_ready;
  logic [AW-1:0]   rd_req_addr;
  logic            rd_rsp_valid;
  logic            rd_rsp_ready;
  logic [DW-1:0]   rd_rsp_data;
  logic            eng_start;
  logic            eng_done = 1'b0;
  logic            busy;
  logic            irq;
  logic [N*DW-1:0] cfg_flat;

  always #4 clk = ~clk;

  cfgq_loader #(.AW(AW), .DW(DW), .NWORDS(N), .IRQ_EN_BIT(IE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_addr(ptr_wr_addr),
    .pending(pending), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .eng_start(eng_start), .eng_done(eng_done),
    .busy(busy), .irq(irq), .cfg_flat(cfg_flat)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a ^ 16'hA5C3, a + (a >> 8)};
  endfunction

  // test-side state (written by initial only)
  int            nchk = 0, nerr = 0;
  int            stall_r = 0, rsp_dly = 0;
  logic [AW-1:0] exp_base = '0;
  int            job_start_cnt = 0;
  logic [N*DW-1:0] prev_cfg = '0;
  bit            finished = 0;

  // memory-model state (written by the model only)
  int            mchk = 0, merr = 0, nreq_tot = 0, cyc = 0, m_dly = 0;
  bit            m_busy = 0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      m_busy       <= 0;
      cyc          <= 0;
    end else begin
      cyc          <= cyc + 1;
      rd_req_ready <= ((cyc % (stall_r + 1)) == 0);
      if (m_busy) begin
        if (rd_rsp_valid && rd_rsp_ready) begin
          mchk = mchk + 1;
          if (cfg_flat !== prev_cfg) begin
            merr = merr + 1;
            $display("FAIL R5: cfg changed mid-fetch act=%h exp=%h", cfg_flat, prev_cfg);
          end
          rd_rsp_valid <= 1'b0;
          m_busy       <= 0;
        end else if (m_dly == 0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= memf(m_addr);
        end else begin
          m_dly <= m_dly - 1;
        end
      end else if (rd_req_valid && rd_req_ready) begin
        mchk = mchk + 1;
        if (rd_req_addr !== exp_base + AW'(4 * (nreq_tot - job_start_cnt))) begin
          merr = merr + 1;
          $display("FAIL R3: req addr act=%h exp=%h", rd_req_addr,
                   exp_base + AW'(4 * (nreq_tot - job_start_cnt)));
        end
        m_busy   <= 1;
        m_addr   <= rd_req_addr;
        m_dly    <= rsp_dly;
        nreq_tot <= nreq_tot + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic write_ptr(input logic [AW-1:0] a);
    @(negedge clk);
    ptr_wr_en   = 1'b1;
    ptr_wr_addr = a;
    @(negedge clk);
    ptr_wr_en   = 1'b0;
  endtask

  task automatic wait_start_check(input logic [AW-1:0] base, input string req);
    int t = 0;
    while (!eng_start && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(eng_start === 1'b1, "R6", "start pulse seen", {31'd0, eng_start}, 32'd1);
    for (int k = 0; k < N; k++)
      chk(cfg_flat[k*DW +: DW] === memf(base + AW'(4 * k)), req, "live word",
          cfg_flat[k*DW +: DW], memf(base + AW'(4 * k)));
    chk(busy === 1'b1, "R6", "busy while running", {31'd0, busy}, 32'd1);
    prev_cfg = cfg_flat;
    @(negedge clk);
    chk(eng_start === 1'b0, "R6", "start one cycle", {31'd0, eng_start}, 32'd0);
  endtask

  task automatic frame_done(input logic exp_irq, input logic exp_busy);
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(irq === exp_irq, "R9", "irq after done", {31'd0, irq}, {31'd0, exp_irq});
    chk(busy === exp_busy, "R6", "busy after done", {31'd0, busy}, {31'd0, exp_busy});
    @(negedge clk);
    chk(irq === 1'b0, "R9", "irq one cycle", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk + mchk, nerr + merr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", "busy", {31'd0, busy}, 0);
    chk(pending === 1'b0, "R1", "pending", {31'd0, pending}, 0);
    chk(eng_start === 1'b0, "R1", "start", {31'd0, eng_start}, 0);
    chk(irq === 1'b0, "R1", "irq", {31'd0, irq}, 0);
    chk(rd_req_valid === 1'b0, "R1", "req_valid", {31'd0, rd_req_valid}, 0);
    chk(cfg_flat === '0, "R1", "cfg zero", cfg_flat[31:0], 0);
    chk(rd_rsp_ready === 1'b0, "R11", "rsp_ready idle", {31'd0, rd_rsp_ready}, 0);

    // R2 / R10: idle write, low bits ignored
    exp_base = 16'h0100;
    job_start_cnt = nreq_tot;
    @(negedge clk);
    ptr_wr_en = 1'b1;
    ptr_wr_addr = 16'h0103;
    @(negedge clk);
    ptr_wr_en = 1'b0;
    chk(pending === 1'b1 && busy === 1'b0, "R2", "pending after write",
        {30'd0, pending, busy}, 32'h2);
    @(negedge clk);
    chk(pending === 1'b0 && busy === 1'b1, "R2", "fetch begun",
        {30'd0, pending, busy}, 32'h1);
    wait_start_check(16'h0100, "R10");
    chk(nreq_tot - job_start_cnt == N, "R3", "request count",
        nreq_tot - job_start_cnt, N);

    // R7 / R8: writes while running
    write_ptr(16'h0200);
    write_ptr(16'h0300);
    chk(pending === 1'b1, "R8", "pending while busy", {31'd0, pending}, 1);
    job_start_cnt = nreq_tot;
    exp_base = 16'h0300;
    repeat (20) @(negedge clk);
    chk(nreq_tot == job_start_cnt, "R7", "no reads before done",
        nreq_tot - job_start_cnt, 0);
    chk(rd_rsp_ready === 1'b0, "R11", "rsp_ready while running", {31'd0, rd_rsp_ready}, 0);
    frame_done(memf(16'h0100)[IE], 1'b1);   // R9 uses old control word
    wait_start_check(16'h0300, "R8");
    chk(nreq_tot - job_start_cnt == N, "R8", "single job", nreq_tot - job_start_cnt, N);
    chk(pending === 1'b0, "R8", "no second job", {31'd0, pending}, 0);
    frame_done(memf(16'h0300)[IE], 1'b0);

    // sweep: request stalls x response delays, R4 / R5 / R9
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 3; d++) begin
        logic [AW-1:0] b;
        b = 16'h0400 + AW'(16'h0040 * (s * 3 + d));
        stall_r = s;
        rsp_dly = d;
        job_start_cnt = nreq_tot;
        exp_base = b;
        write_ptr(b | AW'(s));
        wait_start_check(b, "R5");
        chk(nreq_tot - job_start_cnt == N, "R4", "count under stalls",
            nreq_tot - job_start_cnt, N);
        frame_done(memf(b)[IE], 1'b0);
      end
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk + mchk, nerr + merr);
    $finish;
  end

endmodule